// File: doc/BRIEF.md
# Interrupt gate dispatch unit

This block sits beside a protected-mode core and turns a pending event into a control transfer. The event can be a non-maskable request, an exception vector, a software vector or the maskable external request line. It selects one event, looks up the 8-byte gate descriptor for that vector in a descriptor table, and checks the gate type. A task gate becomes a task-switch request for the task segment selector in the gate. An interrupt gate or a trap gate becomes a procedure entry in the current task. For a procedure entry the block checks privilege and writes the return frame to the stack through a simple request/acknowledge memory port. It then adjusts the enable and single-step flags.

The block holds the table base and limit register, the interrupt-enable flag and the single-step flag. The core writes the table register and reads it back at any time. It sets or clears the enable flag with one-cycle commands. On a return from an event it supplies either the popped flag word or, after a task entry, the enable value that the task-switch logic saved. Task switching, segment loading and external priority resolution belong to other blocks.

Top module: `int_gate_dispatch`

## Requirements
- R1: While the enable flag is 0, the maskable request is never accepted (`acc[3]` stays 0 and the block stays idle). The non-maskable request, exceptions and software vectors are still accepted.
- R2: A one-cycle `if_set` pulse sets the enable flag and a `if_clr` pulse clears it. Reset leaves both the enable and single-step flags at 0.
- R3: A `tbl_we` pulse loads the table base and limit, and they read back on `tbl_base_q` and `tbl_limit_q`. A descriptor is read as one 64-bit word at address base + 8 × vector.
- R4: If byte 8 × vector + 7 lies beyond the limit, the block raises a fault with code 2 and makes no memory access.
- R5: Descriptor bits [34:32] hold the gate type, and only 5 (task), 6 (interrupt) and 7 (trap) are legal. Any other value raises a fault with code 1 and the vector in `fault_vec`.
- R6: A task gate pulses `task_sw_valid` with descriptor bits [31:16] on `task_sel` and performs no stack write.
- R7: Descriptor bits [36:35] hold the target privilege and bit 37 marks a conforming target. Entry is allowed only if target ≤ `cpl` or the target is conforming. Otherwise the block raises a fault with code 3 and performs no stack write.
- R8: A procedure entry writes 16-bit words downward from `stk_ptr`, with the k-th write (k from 0) at `stk_ptr` − 2(k+1). The order is caller SS and SP first, only when a non-conforming target has a lower privilege than `cpl`, then the flag word, the return CS and the return IP. The entry then ends with `proc_valid`, carrying descriptor bits [31:16] and [15:0].
- R9: The pushed flag word is `flags_in` with bit 9 replaced by the enable flag and bit 8 by the single-step flag. After a procedure entry the single-step flag is 0.
- R10: An interrupt gate clears the enable flag on entry. A trap gate leaves it unchanged.
- R11: On `iret_valid` the enable flag takes `iret_flags[9]`, or `iret_task_if` when `iret_task` is 1.
- R12: When several events are pending, the priority is non-maskable (vector NMI_VEC) > exception > software > maskable, shown one-hot on `acc`. While `busy` is 1, no event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| intr_req | input | 1 | maskable external request |
| intr_vec | input | VEC_W | vector of maskable request |
| nmi_req | input | 1 | non-maskable request |
| exc_valid | input | 1 | exception pending |
| exc_vec | input | VEC_W | exception vector |
| sw_valid | input | 1 | software vector pending |
| sw_vec | input | VEC_W | software vector |
| acc | output | 4 | one-hot accept {maskable, software, exception, non-maskable} |
| busy | output | 1 | dispatch in progress |
| if_set | input | 1 | set enable flag |
| if_clr | input | 1 | clear enable flag |
| tf_set | input | 1 | set single-step flag |
| if_q | output | 1 | enable flag |
| tf_q | output | 1 | single-step flag |
| tbl_we | input | 1 | load table register |
| tbl_base_d | input | ADDR_W | new table base |
| tbl_limit_d | input | LIM_W | new table limit |
| tbl_base_q | output | ADDR_W | table base readback |
| tbl_limit_q | output | LIM_W | table limit readback |
| cpl | input | 2 | current privilege level |
| flags_in | input | 16 | current flag word |
| cur_cs | input | 16 | return code selector |
| cur_ip | input | 16 | return instruction pointer |
| cur_ss | input | 16 | caller stack segment |
| cur_sp | input | 16 | caller stack pointer |
| stk_ptr | input | ADDR_W | stack top address for pushes |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | write when 1, read when 0 |
| mem_addr | output | ADDR_W | byte address |
| mem_wdata | output | 16 | write data |
| mem_rdata | input | 64 | descriptor read data |
| mem_ack | input | 1 | request completed |
| task_sw_valid | output | 1 | task-switch request pulse |
| task_sel | output | 16 | task segment selector |
| proc_valid | output | 1 | procedure entry done pulse |
| proc_sel | output | 16 | target code selector |
| proc_off | output | 16 | target entry offset |
| fault_valid | output | 1 | fault pulse |
| fault_code | output | 2 | 1 type, 2 limit, 3 privilege |
| fault_vec | output | VEC_W | faulting vector |
| iret_valid | input | 1 | return from event |
| iret_task | input | 1 | return is from a task entry |
| iret_flags | input | 16 | popped flag word |
| iret_task_if | input | 1 | saved enable value from task logic |

## Verification
The assertions assume that the core issues no `if_set`, `tf_set` or `iret_valid` while `busy` is 1. They also assume that memory acknowledges only a pending request. Without the first assumption, the flag checks at the end of an entry would see values the core had just written. The bench changes flags only between dispatches, after the outcome pulse has been seen. Its memory model asserts `mem_ack` for exactly one cycle per request and never otherwise.

// File: rtl/int_gate_dispatch.sv
module int_gate_dispatch #(
  parameter int VEC_W   = 8,
  parameter int ADDR_W  = 24,
  parameter int LIM_W   = 16,
  parameter int NMI_VEC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              intr_req,
  input  logic [VEC_W-1:0]  intr_vec,
  input  logic              nmi_req,
  input  logic              exc_valid,
  input  logic [VEC_W-1:0]  exc_vec,
  input  logic              sw_valid,
  input  logic [VEC_W-1:0]  sw_vec,
  output logic [3:0]        acc,
  output logic              busy,
  input  logic              if_set,
  input  logic              if_clr,
  input  logic              tf_set,
  output logic              if_q,
  output logic              tf_q,
  input  logic              tbl_we,
  input  logic [ADDR_W-1:0] tbl_base_d,
  input  logic [LIM_W-1:0]  tbl_limit_d,
  output logic [ADDR_W-1:0] tbl_base_q,
  output logic [LIM_W-1:0]  tbl_limit_q,
  input  logic [1:0]        cpl,
  input  logic [15:0]       flags_in,
  input  logic [15:0]       cur_cs,
  input  logic [15:0]       cur_ip,
  input  logic [15:0]       cur_ss,
  input  logic [15:0]       cur_sp,
  input  logic [ADDR_W-1:0] stk_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              task_sw_valid,
  output logic [15:0]       task_sel,
  output logic              proc_valid,
  output logic [15:0]       proc_sel,
  output logic [15:0]       proc_off,
  output logic              fault_valid,
  output logic [1:0]        fault_code,
  output logic [VEC_W-1:0]  fault_vec,
  input  logic              iret_valid,
  input  logic              iret_task,
  input  logic [15:0]       iret_flags,
  input  logic              iret_task_if
);

  localparam int CW = (VEC_W + 3 > LIM_W) ? VEC_W + 3 : LIM_W;

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_FETCH, S_EVAL, S_PUSH} st_t;
  st_t st;

  logic [VEC_W-1:0]  vec_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [63:0]       desc_q;
  logic [15:0]       fl_q, cs_q, ip_q, ss_q, sp_q;
  logic [2:0]        pidx;
  logic              gate_int_q;

  wire idle = (st == S_IDLE);
  assign busy = !idle;

  assign acc[0] = idle & nmi_req;
  assign acc[1] = idle & !nmi_req & exc_valid;
  assign acc[2] = idle & !nmi_req & !exc_valid & sw_valid;
  assign acc[3] = idle & !nmi_req & !exc_valid & !sw_valid & intr_req & if_q;

  wire [VEC_W-1:0] sel_vec = nmi_req   ? VEC_W'(NMI_VEC) :
                             exc_valid ? exc_vec :
                             sw_valid  ? sw_vec  : intr_vec;

  wire [2:0] gtype = desc_q[34:32];
  wire [1:0] gdpl  = desc_q[36:35];
  wire       gconf = desc_q[37];
  wire       priv_ok  = (gdpl <= cpl) || gconf;
  wire       ring_chg = !gconf && (gdpl < cpl);
  wire       past_lim = CW'({vec_q, 3'b111}) > CW'(tbl_limit_q);

  assign mem_req   = (st == S_FETCH) || (st == S_PUSH);
  assign mem_we    = (st == S_PUSH);
  assign mem_addr  = (st == S_FETCH) ? tbl_base_q + ADDR_W'({vec_q, 3'b000})
                                     : ptr_q - ADDR_W'(2);

  always_comb begin
    case (pidx)
      3'd0:    mem_wdata = ss_q;
      3'd1:    mem_wdata = sp_q;
      3'd2:    mem_wdata = fl_q;
      3'd3:    mem_wdata = cs_q;
      default: mem_wdata = ip_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_base_q  <= '0;
      tbl_limit_q <= '0;
    end else if (tbl_we) begin
      tbl_base_q  <= tbl_base_d;
      tbl_limit_q <= tbl_limit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      vec_q <= '0; ptr_q <= '0; desc_q <= '0;
      fl_q <= '0; cs_q <= '0; ip_q <= '0; ss_q <= '0; sp_q <= '0;
      pidx <= '0; gate_int_q <= 1'b0;
      if_q <= 1'b0; tf_q <= 1'b0;
      task_sw_valid <= 1'b0; task_sel <= '0;
      proc_valid <= 1'b0; proc_sel <= '0; proc_off <= '0;
      fault_valid <= 1'b0; fault_code <= '0; fault_vec <= '0;
    end else begin
      task_sw_valid <= 1'b0;
      proc_valid    <= 1'b0;
      fault_valid   <= 1'b0;

      if (iret_valid)  if_q <= iret_task ? iret_task_if : iret_flags[9];
      else if (if_clr) if_q <= 1'b0;
      else if (if_set) if_q <= 1'b1;
      if (tf_set) tf_q <= 1'b1;

      case (st)
        S_IDLE: if (|acc) begin
          vec_q <= sel_vec;
          cs_q <= cur_cs; ip_q <= cur_ip; ss_q <= cur_ss; sp_q <= cur_sp;
          st <= S_CHK;
        end
        S_CHK: begin
          if (past_lim) begin
            fault_valid <= 1'b1; fault_code <= 2'd2; fault_vec <= vec_q;
            st <= S_IDLE;
          end else st <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          desc_q <= mem_rdata;
          st <= S_EVAL;
        end
        S_EVAL: begin
          if (gtype < 3'd5) begin
            fault_valid <= 1'b1; fault_code <= 2'd1; fault_vec <= vec_q;
            st <= S_IDLE;
          end else if (gtype == 3'd5) begin
            task_sw_valid <= 1'b1; task_sel <= desc_q[31:16];
            st <= S_IDLE;
          end else if (!priv_ok) begin
            fault_valid <= 1'b1; fault_code <= 2'd3; fault_vec <= vec_q;
            st <= S_IDLE;
          end else begin
            fl_q <= {flags_in[15:10], if_q, tf_q, flags_in[7:0]};
            pidx <= ring_chg ? 3'd0 : 3'd2;
            ptr_q <= stk_ptr;
            gate_int_q <= (gtype == 3'd6);
            tf_q <= 1'b0;
            if (gtype == 3'd6) if_q <= 1'b0;
            st <= S_PUSH;
          end
        end
        S_PUSH: if (mem_ack) begin
          ptr_q <= ptr_q - ADDR_W'(2);
          if (pidx == 3'd4) begin
            proc_valid <= 1'b1;
            proc_sel <= desc_q[31:16];
            proc_off <= desc_q[15:0];
            st <= S_IDLE;
          end else pidx <= pidx + 3'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({task_sw_valid, proc_valid, fault_valid}));

  p_nmi_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !busy) |-> acc[0]);

  p_busy_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (acc == 4'b0000));

  p_task_nopush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw_valid |-> !$past(mem_we));

  p_limit_noread_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_code == 2'd2) |-> !$past(mem_req));

  p_tf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proc_valid |-> !tf_q);

  p_intgate_if_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_valid && gate_int_q) |-> !if_q);

  p_push_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_ack && pidx != 3'd4) |=> (mem_we && $past(mem_addr) - ADDR_W'(2) == mem_addr));

endmodule

// File: tb/sim_int_gate_dispatch.sv
`timescale 1ns/1ps
module sim_int_gate_dispatch;
  localparam int VEC_W = 8, ADDR_W = 24, LIM_W = 16;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic intr_req = 0, nmi_req = 0, exc_valid = 0, sw_valid = 0;
  logic [VEC_W-1:0] intr_vec = 0, exc_vec = 0, sw_vec = 0;
  logic [3:0] acc; logic busy;
  logic if_set = 0, if_clr = 0, tf_set = 0, if_q, tf_q;
  logic tbl_we = 0; logic [ADDR_W-1:0] tbl_base_d = 0, tbl_base_q;
  logic [LIM_W-1:0] tbl_limit_d = 0, tbl_limit_q;
  logic [1:0] cpl = 0;
  logic [15:0] flags_in = 16'h00C5, cur_cs = 16'h1234, cur_ip = 16'h5678;
  logic [15:0] cur_ss = 16'h9ABC, cur_sp = 16'hDEF0;
  logic [ADDR_W-1:0] stk_ptr = 24'h008000;
  logic mem_req, mem_we, mem_ack = 0; logic [ADDR_W-1:0] mem_addr;
  logic [15:0] mem_wdata; logic [63:0] mem_rdata;
  logic task_sw_valid, proc_valid, fault_valid;
  logic [15:0] task_sel, proc_sel, proc_off; logic [1:0] fault_code;
  logic [VEC_W-1:0] fault_vec;
  logic iret_valid = 0, iret_task = 0, iret_task_if = 0; logic [15:0] iret_flags = 0;

  int_gate_dispatch u0 (.*);

  logic [63:0] desc [0:31];
  assign mem_rdata = desc[mem_addr[7:3]];

  int wr_cnt, rd_cnt;
  logic [ADDR_W-1:0] wr_addr [0:7];
  logic [15:0] wr_data [0:7];
  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        if (wr_cnt < 8) begin wr_addr[wr_cnt] = mem_addr; wr_data[wr_cnt] = mem_wdata; end
        wr_cnt = wr_cnt + 1;
      end else rd_cnt = rd_cnt + 1;
    end
  end

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin failures++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  int outc; logic [15:0] o_sel, o_off; logic [1:0] o_code; logic [7:0] o_vec;
  task automatic wait_out();
    outc = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (task_sw_valid) begin outc = 1; o_sel = task_sel; break; end
      if (proc_valid) begin outc = 2; o_sel = proc_sel; o_off = proc_off; break; end
      if (fault_valid) begin outc = 3; o_code = fault_code; o_vec = fault_vec; break; end
    end
  endtask

  task automatic fire(input logic [7:0] v);
    wr_cnt = 0; rd_cnt = 0;
    @(negedge clk); sw_valid = 1; sw_vec = v;
    @(negedge clk); sw_valid = 0;
    wait_out();
  endtask

  task automatic pulse_if(input bit s);
    @(negedge clk); if (s) if_set = 1; else if_clr = 1;
    @(negedge clk); if_set = 0; if_clr = 0;
  endtask

  task automatic pulse_tf();
    @(negedge clk); tf_set = 1; @(negedge clk); tf_set = 0;
  endtask

  function automatic logic [63:0] mk(input int ty, input int dpl, input bit conf,
                                     input logic [15:0] sel, input logic [15:0] off);
    return {26'd0, conf, 2'(dpl), 3'(ty), sel, off};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) desc[i] = 64'd0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(if_q == 0 && tf_q == 0, "R2 reset flags", {if_q, tf_q}, 0);
    chk(busy == 0 && acc == 0, "R12 reset idle", {busy, acc}, 0);
    rst_n = 1;
    // R3 table register
    @(negedge clk); tbl_we = 1; tbl_base_d = 24'h001000; tbl_limit_d = 16'd255;
    @(negedge clk); tbl_we = 0;
    chk(tbl_base_q == 24'h001000, "R3 base readback", tbl_base_q, 24'h001000);
    chk(tbl_limit_q == 255, "R3 limit readback", tbl_limit_q, 255);
    // R2 set/clear
    pulse_if(1); chk(if_q == 1, "R2 set", if_q, 1);
    pulse_if(0); chk(if_q == 0, "R2 clear", if_q, 0);
    // R1 masked request ignored
    intr_req = 1; intr_vec = 8'd7;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(acc[3] == 0 && busy == 0, "R1 masked request", {acc, busy}, 0);
    end
    intr_req = 0;
    // R1 exception accepted while masked; type 0 gives R5 fault
    desc[3] = mk(0, 0, 0, 16'h0, 16'h0);
    wr_cnt = 0; rd_cnt = 0;
    @(negedge clk); exc_valid = 1; exc_vec = 8'd3;
    @(negedge clk); exc_valid = 0;
    wait_out();
    chk(outc == 3 && o_vec == 3, "R1 exception while masked", o_vec, 3);
    // R5 type sweep over illegal codes
    for (int t = 0; t < 5; t++) begin
      desc[9] = mk(t, 0, 0, 16'h0, 16'h0);
      fire(8'd9);
      chk(outc == 3 && o_code == 1 && o_vec == 9, "R5 illegal type", {outc, o_code}, {32'd3, 2'd1});
      chk(wr_cnt == 0 && rd_cnt == 1, "R5 one read no write", wr_cnt, 0);
    end
    // R6 task gate
    desc[11] = mk(5, 3, 0, 16'hABC8, 16'h0);
    fire(8'd11);
    chk(outc == 1 && o_sel == 16'hABC8, "R6 task selector", o_sel, 16'hABC8);
    chk(wr_cnt == 0, "R6 no pushes", wr_cnt, 0);
    // R4 limit boundary: vec 31 fits, vec 32 does not
    desc[31] = mk(5, 0, 0, 16'h0031, 16'h0);
    fire(8'd31);
    chk(outc == 1 && rd_cnt == 1, "R4 last vector in range", outc, 1);
    fire(8'd32);
    chk(outc == 3 && o_code == 2, "R4 limit fault", o_code, 2);
    chk(rd_cnt == 0 && wr_cnt == 0, "R4 no memory access", rd_cnt, 0);
    // R7 R8 R9 R10 sweep over gate kind, levels and conforming bit
    for (int g = 6; g < 8; g++)
      for (int c = 0; c < 4; c++)
        for (int d = 0; d < 4; d++)
          for (int cf = 0; cf < 2; cf++) begin
            bit ok, rc; int n; logic [15:0] expw [0:4]; logic [15:0] fexp;
            cpl = 2'(c);
            desc[5] = mk(g, d, cf[0], 16'h4000 + 16'(g*32 + c*8 + d*2 + cf), 16'h0100 + 16'(d));
            pulse_if(1); pulse_tf();
            fire(8'd5);
            ok = (d <= c) || cf;
            rc = !cf && (d < c);
            if (!ok) begin
              chk(outc == 3 && o_code == 3, "R7 privilege fault", o_code, 3);
              chk(wr_cnt == 0, "R7 no pushes on fault", wr_cnt, 0);
            end else begin
              fexp = flags_in | 16'h0300;
              expw[0] = cur_ss; expw[1] = cur_sp; expw[2] = fexp; expw[3] = cur_cs; expw[4] = cur_ip;
              n = rc ? 5 : 3;
              chk(outc == 2, "R7 entry allowed", outc, 2);
              chk(o_sel == desc[5][31:16] && o_off == desc[5][15:0], "R8 target", o_off, desc[5][15:0]);
              chk(wr_cnt == n, "R8 push count", wr_cnt, n);
              for (int k = 0; k < n && k < 8; k++) begin
                chk(wr_addr[k] == stk_ptr - 24'(2*(k+1)), "R8 push address", wr_addr[k], stk_ptr - 24'(2*(k+1)));
                chk(wr_data[k] == expw[k + 5 - n], "R9 push data", wr_data[k], expw[k + 5 - n]);
              end
              chk(tf_q == 0, "R9 single-step cleared", tf_q, 0);
              chk(if_q == (g == 7), "R10 enable after entry", if_q, (g == 7));
            end
          end
    // R11 return restores
    pulse_if(0);
    @(negedge clk); iret_valid = 1; iret_task = 0; iret_flags = 16'h0200;
    @(negedge clk); iret_valid = 0;
    chk(if_q == 1, "R11 restore from flags", if_q, 1);
    @(negedge clk); iret_valid = 1; iret_flags = 16'h0000;
    @(negedge clk); iret_valid = 0;
    chk(if_q == 0, "R11 restore clear from flags", if_q, 0);
    @(negedge clk); iret_valid = 1; iret_task = 1; iret_task_if = 1; iret_flags = 16'h0000;
    @(negedge clk); iret_valid = 0; iret_task = 0;
    chk(if_q == 1, "R11 restore from task", if_q, 1);
    // R12 priority, combinational view between edges
    @(negedge clk); nmi_req = 1; exc_valid = 1; sw_valid = 1; intr_req = 1; #0.2;
    chk(acc == 4'b0001, "R12 nmi first", acc, 1);
    nmi_req = 0; #0.2; chk(acc == 4'b0010, "R12 exception second", acc, 2);
    exc_valid = 0; #0.2; chk(acc == 4'b0100, "R12 software third", acc, 4);
    sw_valid = 0; #0.2; chk(acc == 4'b1000, "R1 maskable when enabled", acc, 8);
    intr_req = 0;
    // R12 NMI uses its fixed vector
    desc[2] = mk(1, 0, 0, 16'h0, 16'h0);
    wr_cnt = 0; rd_cnt = 0;
    @(negedge clk); nmi_req = 1;
    @(negedge clk); nmi_req = 0;
    wait_out();
    chk(outc == 3 && o_vec == 2, "R12 nmi vector", o_vec, 2);
    // R12 busy blocks
    desc[6] = mk(7, 0, 0, 16'h0008, 16'h0040);
    cpl = 0;
    @(negedge clk); sw_valid = 1; sw_vec = 8'd6;
    @(negedge clk); sw_valid = 0; nmi_req = 1; #0.2;
    chk(busy == 1 && acc == 0, "R12 busy blocks nmi", {busy, acc}, 5'b10000);
    @(negedge clk); nmi_req = 0;
    wait_out();
    chk(outc == 2, "R12 blocked run completes", outc, 2);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R12 idle after dispatch", busy, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule